// File: doc/BRIEF.md
# Read Queue Partition and Priority Classifier

This block sits at the request entry of a memory controller. Each incoming request is a read or a write carrying a priority tag. The block maps that tag to one of four internal classes: low-priority read, high-priority read, normal write or variable write. It then decides in the same cycle whether a free storage entry exists for that class.

A single shared read storage of `CAM_DEPTH` entries is split in two by a programmable count. One part is the low-priority read pool and the rest is the high-priority read pool. Writes draw from a separate pool whose size is fixed when the block is built. An error-correction enable holds back one entry in the low-priority read pool and one in the write pool for correction read-modify-write traffic. A global active-low demotion input folds all requests into the low-priority classes and turns off the read bypass path.

Credits are taken when a request is accepted and returned one at a time on per-pool completion inputs. The entry storage and command scheduling live outside this block. Configuration inputs are treated as static: they change only while the block is held in reset.

Top module: `rdq_part_classifier`

## Requirements
- R1: After reset, no credit is outstanding. With the entry-count field at 0x20, error correction off and no demotion, all three pools report a credit available.
- R2: With `cfg_force_low_n`=1, read tags map as follows: `req_prio` 0 and 3 give class 0 (low read), and 1 (variable) and 2 (high) give class 1 (high read). For writes, `req_prio[0]`=1 gives class 3 (variable write) and `req_prio[0]`=0 gives class 2 (normal write).
- R3: With `cfg_force_low_n`=0, every read is class 0 and every write is class 2, whatever its tag.
- R4: `bypass_en` is 1 when `cfg_force_low_n`=1 and 0 when it is 0.
- R5: The low-priority read pool holds `cfg_lp_entries`+1 credits, less one when `cfg_ecc_en`=1. Once that many requests are accepted with no release, further low reads are refused.
- R6: The high-priority read pool holds `CAM_DEPTH`-(`cfg_lp_entries`+1) credits.
- R7: A field value of 0 gives the low pool 1 credit and the high pool `CAM_DEPTH`-1. The all-ones value gives the low pool every entry and the high pool none, so `hpr_avail` stays 0.
- R8: `cfg_ecc_en`=1 reduces the low-read pool and the write pool by one credit each and leaves the high-read pool unchanged.
- R9: Classes 2 and 3 share one write pool of `WR_DEPTH` credits, less one under error correction.
- R10: `req_accept` is 1 in the same cycle as `req_valid` exactly when the pool of the resolved class has a free credit. A refused request leaves every pool count unchanged.
- R11: A completion pulse on a pool with no outstanding credit is ignored: the pool's capacity afterwards is still exactly its configured size.
- R12: An accept and a completion on the same pool in one cycle, with credits outstanding, leave that pool's outstanding count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_lp_entries | input | 6 | Low-read pool size minus one |
| cfg_force_low_n | input | 1 | 0 demotes all requests to low classes |
| cfg_ecc_en | input | 1 | Reserve one low-read and one write entry |
| req_valid | input | 1 | Request present |
| req_is_write | input | 1 | 1 = write, 0 = read |
| req_prio | input | 2 | Priority tag (see R2) |
| rel_lpr | input | 1 | Return one low-read credit |
| rel_hpr | input | 1 | Return one high-read credit |
| rel_wr | input | 1 | Return one write credit |
| req_class | output | 2 | Resolved class (0 low read, 1 high read, 2 normal write, 3 variable write) |
| req_accept | output | 1 | Request accepted this cycle |
| lpr_avail | output | 1 | Low-read credit free |
| hpr_avail | output | 1 | High-read credit free |
| wr_avail | output | 1 | Write credit free |
| bypass_en | output | 1 | Read bypass path permitted |

## Verification
The hardest state to reach is a pool sitting exactly one credit below its limit while a completion for that same pool coincides with a new request. The stimulus gets there by filling a pool to one short of its computed capacity, issuing the accept and the release together, and then proving that exactly one further accept fits. The all-ones and zero field values, and error correction with a field of zero (which leaves the low pool with no credit), come from directed resets. Fixed-seed random rounds then mix random field values, demotion and releases against a bench credit model.

// File: rtl/rdq_pkg.sv
package rdq_pkg;

   typedef enum logic [1:0] {
      CLS_LOW_RD  = 2'd0,
      CLS_HIGH_RD = 2'd1,
      CLS_NORM_WR = 2'd2,
      CLS_VAR_WR  = 2'd3
   } rd_class_e;

   localparam int NPOOL   = 3;
   localparam int POOL_LO = 0;
   localparam int POOL_HI = 1;
   localparam int POOL_WR = 2;

   localparam logic [1:0] TAG_RD_LOW  = 2'd0;
   localparam logic [1:0] TAG_RD_VAR  = 2'd1;
   localparam logic [1:0] TAG_RD_HIGH = 2'd2;

   function automatic logic [NPOOL-1:0] pool_sel(input rd_class_e c);
      logic [NPOOL-1:0] s;
      s = '0;
      case (c)
         CLS_LOW_RD:  s[POOL_LO] = 1'b1;
         CLS_HIGH_RD: s[POOL_HI] = 1'b1;
         default:     s[POOL_WR] = 1'b1;
      endcase
      return s;
   endfunction

endpackage

// File: rtl/rdq_classifier.sv
module rdq_classifier
   import rdq_pkg::*;
(
   input  logic       is_write,
   input  logic [1:0] prio,
   input  logic       force_low_n,
   output rd_class_e  cls,
   output logic       bypass_ok
);

   rd_class_e rd_cls;
   rd_class_e wr_cls;

   always_comb begin
      if (!force_low_n) begin
         rd_cls = CLS_LOW_RD;
      end else if (prio == TAG_RD_VAR || prio == TAG_RD_HIGH) begin
         rd_cls = CLS_HIGH_RD;
      end else begin
         rd_cls = CLS_LOW_RD;
      end
   end

   always_comb begin
      if (force_low_n && prio[0]) wr_cls = CLS_VAR_WR;
      else                        wr_cls = CLS_NORM_WR;
   end

   assign cls       = is_write ? wr_cls : rd_cls;
   assign bypass_ok = force_low_n;

endmodule

// File: rtl/rdq_cap_calc.sv
module rdq_cap_calc
   import rdq_pkg::*;
#(
   parameter int CAM_DEPTH = 64,
   parameter int WR_DEPTH  = 32,
   parameter int FW        = $clog2(CAM_DEPTH),
   parameter int CNT_W     = 8
)(
   input  logic [FW-1:0]                field,
   input  logic                         ecc_en,
   output logic [NPOOL-1:0][CNT_W-1:0]  cap
);

   localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(CAM_DEPTH);
   localparam logic [CNT_W-1:0] WR_C    = CNT_W'(WR_DEPTH);
   localparam logic [CNT_W-1:0] ONE_C   = CNT_W'(1);

   logic [CNT_W-1:0] lo_raw;
   logic [CNT_W-1:0] rsv;

   always_comb begin
      lo_raw       = CNT_W'(field) + ONE_C;
      rsv          = ecc_en ? ONE_C : '0;
      cap[POOL_LO] = lo_raw - rsv;
      cap[POOL_HI] = DEPTH_C - lo_raw;
      cap[POOL_WR] = WR_C - rsv;
   end

endmodule

// File: rtl/rdq_credit_pool.sv
module rdq_credit_pool #(
   parameter int CNT_W = 8
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] cap,
   input  logic             take_req,
   input  logic             give,
   output logic             avail,
   output logic             granted,
   output logic [CNT_W-1:0] used
);

   logic give_ok;

   assign avail   = used < cap;
   assign granted = take_req && avail;
   assign give_ok = give && (used != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         used <= '0;
      end else if (granted && !give_ok) begin
         used <= used + 1'b1;
      end else if (give_ok && !granted) begin
         used <= used - 1'b1;
      end
   end

endmodule

// File: rtl/rdq_part_classifier.sv
module rdq_part_classifier
   import rdq_pkg::*;
#(
   parameter int CAM_DEPTH = 64,
   parameter int WR_DEPTH  = 32,
   parameter int FW        = $clog2(CAM_DEPTH)
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic [FW-1:0] cfg_lp_entries,
   input  logic          cfg_force_low_n,
   input  logic          cfg_ecc_en,
   input  logic          req_valid,
   input  logic          req_is_write,
   input  logic [1:0]    req_prio,
   input  logic          rel_lpr,
   input  logic          rel_hpr,
   input  logic          rel_wr,
   output logic [1:0]    req_class,
   output logic          req_accept,
   output logic          lpr_avail,
   output logic          hpr_avail,
   output logic          wr_avail,
   output logic          bypass_en
);

   localparam int MAXD  = (CAM_DEPTH > WR_DEPTH) ? CAM_DEPTH : WR_DEPTH;
   localparam int CNT_W = $clog2(MAXD + 1);

   generate
      if (CAM_DEPTH < 2 || (CAM_DEPTH & (CAM_DEPTH - 1)) != 0) begin : g_bad_depth
         $error("CAM_DEPTH must be a power of two of at least 2");
      end
      if (WR_DEPTH < 2) begin : g_bad_wr
         $error("WR_DEPTH must be at least 2");
      end
      if (FW != $clog2(CAM_DEPTH)) begin : g_bad_fw
         $error("FW must equal clog2(CAM_DEPTH)");
      end
   endgenerate

   rd_class_e                       cls;
   logic [NPOOL-1:0]                sel;
   logic [NPOOL-1:0]                rel_vec;
   logic [NPOOL-1:0]                grant;
   logic [NPOOL-1:0]                avail;
   logic [NPOOL-1:0][CNT_W-1:0]     cap;
   logic [NPOOL-1:0][CNT_W-1:0]     used_cnt;

   rdq_classifier u_cls (
      .is_write    (req_is_write),
      .prio        (req_prio),
      .force_low_n (cfg_force_low_n),
      .cls         (cls),
      .bypass_ok   (bypass_en)
   );

   rdq_cap_calc #(
      .CAM_DEPTH (CAM_DEPTH),
      .WR_DEPTH  (WR_DEPTH),
      .FW        (FW),
      .CNT_W     (CNT_W)
   ) u_cap (
      .field  (cfg_lp_entries),
      .ecc_en (cfg_ecc_en),
      .cap    (cap)
   );

   assign sel     = req_valid ? pool_sel(cls) : '0;
   assign rel_vec = {rel_wr, rel_hpr, rel_lpr};

   generate
      for (genvar i = 0; i < NPOOL; i++) begin : g_pool
         rdq_credit_pool #(.CNT_W(CNT_W)) u_pool (
            .clk      (clk),
            .rst_n    (rst_n),
            .cap      (cap[i]),
            .take_req (sel[i]),
            .give     (rel_vec[i]),
            .avail    (avail[i]),
            .granted  (grant[i]),
            .used     (used_cnt[i])
         );
      end
   endgenerate

   assign req_class  = cls;
   assign req_accept = |grant;
   assign lpr_avail  = avail[POOL_LO];
   assign hpr_avail  = avail[POOL_HI];
   assign wr_avail   = avail[POOL_WR];

endmodule

// File: rtl/rdq_part_checker.sv
module rdq_part_checker
   import rdq_pkg::*;
#(
   parameter int FW    = 6,
   parameter int CNT_W = 7
)(
   input logic                        clk,
   input logic                        rst_n,
   input logic [FW-1:0]               cfg_lp_entries,
   input logic                        cfg_force_low_n,
   input logic                        req_valid,
   input logic                        req_is_write,
   input logic [1:0]                  req_class,
   input logic                        req_accept,
   input logic                        lpr_avail,
   input logic                        hpr_avail,
   input logic                        wr_avail,
   input logic [NPOOL-1:0]            rel_vec,
   input logic [NPOOL-1:0]            grant,
   input logic [NPOOL-1:0][CNT_W-1:0] used_cnt,
   input logic [NPOOL-1:0][CNT_W-1:0] cap
);

   logic cls_avail;
   always_comb begin
      case (req_class)
         2'd0:    cls_avail = lpr_avail;
         2'd1:    cls_avail = hpr_avail;
         default: cls_avail = wr_avail;
      endcase
   end

   AST_ACCEPT_CREDIT: assert property (@(posedge clk) disable iff (!rst_n)
      req_accept |-> (req_valid && cls_avail)); // R10

   AST_FORCE_READ_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_force_low_n && req_valid && !req_is_write) |-> (req_class == 2'd0)); // R3

   AST_HPR_NONE_AT_MAX: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_lp_entries == '1) |-> !hpr_avail); // R7

   generate
      for (genvar i = 0; i < NPOOL; i++) begin : g_chk
         AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
            used_cnt[i] <= cap[i]); // R5

         AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
            (rel_vec[i] && !grant[i] && used_cnt[i] == '0) |=> (used_cnt[i] == '0)); // R11

         AST_SIMUL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (rel_vec[i] && grant[i] && used_cnt[i] != '0) |=> $stable(used_cnt[i])); // R12
      end
   endgenerate

endmodule

bind rdq_part_classifier rdq_part_checker #(
   .FW    (FW),
   .CNT_W (CNT_W)
) u_chk (
   .clk             (clk),
   .rst_n           (rst_n),
   .cfg_lp_entries  (cfg_lp_entries),
   .cfg_force_low_n (cfg_force_low_n),
   .req_valid       (req_valid),
   .req_is_write    (req_is_write),
   .req_class       (req_class),
   .req_accept      (req_accept),
   .lpr_avail       (lpr_avail),
   .hpr_avail       (hpr_avail),
   .wr_avail        (wr_avail),
   .rel_vec         (rel_vec),
   .grant           (grant),
   .used_cnt        (used_cnt),
   .cap             (cap)
);

// File: tb/sim_rdq_part_classifier.sv
`timescale 1ns/1ps
module sim_rdq_part_classifier;

   localparam int DEPTH = 64;
   localparam int WRD   = 32;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [5:0] cfg_lp_entries = 6'h20;
   logic       cfg_force_low_n = 1'b1;
   logic       cfg_ecc_en = 1'b0;
   logic       req_valid = 1'b0;
   logic       req_is_write = 1'b0;
   logic [1:0] req_prio = 2'd0;
   logic       rel_lpr = 1'b0, rel_hpr = 1'b0, rel_wr = 1'b0;
   logic [1:0] req_class;
   logic       req_accept, lpr_avail, hpr_avail, wr_avail, bypass_en;

   int checks = 0;
   int fails  = 0;
   int used_m [3];

   always #10 clk = ~clk;

   rdq_part_classifier #(.CAM_DEPTH(DEPTH), .WR_DEPTH(WRD)) u0 (
      .clk(clk), .rst_n(rst_n), .cfg_lp_entries(cfg_lp_entries),
      .cfg_force_low_n(cfg_force_low_n), .cfg_ecc_en(cfg_ecc_en),
      .req_valid(req_valid), .req_is_write(req_is_write), .req_prio(req_prio),
      .rel_lpr(rel_lpr), .rel_hpr(rel_hpr), .rel_wr(rel_wr),
      .req_class(req_class), .req_accept(req_accept), .lpr_avail(lpr_avail),
      .hpr_avail(hpr_avail), .wr_avail(wr_avail), .bypass_en(bypass_en));

   function automatic int exp_class(input logic w, input logic [1:0] p, input logic fn);
      if (!w) return (fn && (p == 2'd1 || p == 2'd2)) ? 1 : 0;
      return (fn && p[0]) ? 3 : 2;
   endfunction

   function automatic int pool_of(input int c);
      return (c < 2) ? c : 2;
   endfunction

   function automatic int exp_cap(input int pool, input int f, input logic e);
      if (pool == 0) return f + 1 - int'(e);
      if (pool == 1) return DEPTH - (f + 1);
      return WRD - int'(e);
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic do_reset(input int f, input logic e, input logic fn);
      @(negedge clk);
      rst_n = 1'b0;
      req_valid = 1'b0; rel_lpr = 1'b0; rel_hpr = 1'b0; rel_wr = 1'b0;
      cfg_lp_entries = 6'(f); cfg_ecc_en = e; cfg_force_low_n = fn;
      for (int i = 0; i < 3; i++) used_m[i] = 0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   // one cycle: drive at falling edge, sample combinational outputs 1 ns later
   task automatic step(input logic v, input logic w, input logic [1:0] p,
                       input logic [2:0] rel, output logic acc, output int cls);
      @(negedge clk);
      req_valid = v; req_is_write = w; req_prio = p;
      rel_lpr = rel[0]; rel_hpr = rel[1]; rel_wr = rel[2];
      #1;
      acc = req_accept;
      cls = int'(req_class);
   endtask

   task automatic idle();
      logic a; int c;
      step(1'b0, 1'b0, 2'd0, 3'b000, a, c);
   endtask

   task automatic fill(input logic w, input logic [1:0] p, input int limit, output int n);
      logic a; int c;
      n = 0;
      for (int k = 0; k < limit; k++) begin
         step(1'b1, w, p, 3'b000, a, c);
         if (a) n++;
      end
      idle();
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      logic a; int c; int n;

      // R1 / R4: default configuration
      do_reset(32, 1'b0, 1'b1);
      idle();
      chk("R1 lpr_avail", lpr_avail, 1);
      chk("R1 hpr_avail", hpr_avail, 1);
      chk("R1 wr_avail", wr_avail, 1);
      chk("R4 bypass on", bypass_en, 1);

      // R2: mapping without demotion
      for (int t = 0; t < 8; t++) begin
         step(1'b1, t[2], t[1:0], 3'b000, a, c);
         chk("R2 class map", c, exp_class(t[2], t[1:0], 1'b1));
      end
      // R3 / R4: demotion
      do_reset(32, 1'b0, 1'b0);
      for (int t = 0; t < 8; t++) begin
         step(1'b1, t[2], t[1:0], 3'b000, a, c);
         chk("R3 forced class", c, t[2] ? 2 : 0);
      end
      chk("R4 bypass off", bypass_en, 0);

      // R5 R6 R9 R10: capacities at default field
      do_reset(32, 1'b0, 1'b1);
      fill(1'b0, 2'd0, 70, n); chk("R5 lpr capacity", n, 33);
      fill(1'b0, 2'd2, 70, n); chk("R6 hpr capacity", n, 31);
      fill(1'b1, 2'd0, 10, n); chk("R9 npw part", n, 10);
      fill(1'b1, 2'd1, 40, n); chk("R9 shared write pool", n, 22);
      step(1'b1, 1'b0, 2'd0, 3'b000, a, c);
      chk("R10 refused when full", a, 0);
      chk("R10 lpr_avail low", lpr_avail, 0);
      idle();
      step(1'b1, 1'b0, 2'd0, 3'b001, a, c);
      chk("R10 still refused during release cycle", a, 0);
      step(1'b1, 1'b0, 2'd0, 3'b000, a, c);
      chk("R10 accepted after release", a, 1);
      idle();

      // R7: field extremes
      do_reset(0, 1'b0, 1'b1);
      fill(1'b0, 2'd0, 70, n); chk("R7 lpr at field 0", n, 1);
      fill(1'b0, 2'd1, 70, n); chk("R7 hpr at field 0", n, 63);
      do_reset(63, 1'b0, 1'b1);
      idle();
      chk("R7 hpr_avail at max", hpr_avail, 0);
      fill(1'b0, 2'd2, 5, n);  chk("R7 hpr none at max", n, 0);
      fill(1'b0, 2'd0, 70, n); chk("R7 lpr all at max", n, 64);

      // R8: error-correction reserve
      do_reset(32, 1'b1, 1'b1);
      fill(1'b0, 2'd0, 70, n); chk("R8 lpr with ecc", n, 32);
      fill(1'b0, 2'd1, 70, n); chk("R8 hpr with ecc", n, 31);
      fill(1'b1, 2'd3, 70, n); chk("R8 wr with ecc", n, 31);
      do_reset(0, 1'b1, 1'b1);
      idle();
      chk("R8 lpr empty at field 0 with ecc", lpr_avail, 0);

      // R11: release with nothing outstanding
      do_reset(4, 1'b0, 1'b1);
      for (int k = 0; k < 3; k++) step(1'b0, 1'b0, 2'd0, 3'b111, a, c);
      idle();
      fill(1'b0, 2'd0, 20, n); chk("R11 lpr unchanged by stray release", n, 5);
      fill(1'b1, 2'd0, 40, n); chk("R11 wr unchanged by stray release", n, WRD);

      // R12: simultaneous accept and release one below the limit
      do_reset(4, 1'b0, 1'b1);
      fill(1'b0, 2'd0, 4, n);
      step(1'b1, 1'b0, 2'd0, 3'b001, a, c);
      chk("R12 accept with release", a, 1);
      step(1'b1, 1'b0, 2'd0, 3'b000, a, c);
      chk("R12 one more fits", a, 1);
      step(1'b1, 1'b0, 2'd0, 3'b000, a, c);
      chk("R12 then full", a, 0);
      idle();

      // random rounds against a credit model (R2 R3 R5 R6 R8 R9 R10)
      void'($urandom(32'd1234));
      for (int r = 0; r < 40; r++) begin
         int f; logic e; logic fn;
         f  = int'($urandom_range(0, 63));
         e  = 1'($urandom_range(0, 1));
         fn = ($urandom_range(0, 3) != 0);
         do_reset(f, e, fn);
         for (int k = 0; k < 300; k++) begin
            logic v, w; logic [1:0] p; logic [2:0] rl;
            int ec, ep; logic eacc; logic [2:0] g;
            v  = ($urandom_range(0, 3) != 0);
            w  = 1'($urandom_range(0, 1));
            p  = 2'($urandom_range(0, 3));
            rl = 3'($urandom_range(0, 7)) & 3'($urandom_range(0, 7));
            ec = exp_class(w, p, fn);
            ep = pool_of(ec);
            step(v, w, p, rl, a, c);
            chk("R5 lpr_avail model", lpr_avail, int'(used_m[0] < exp_cap(0, f, e)));
            chk("R6 hpr_avail model", hpr_avail, int'(used_m[1] < exp_cap(1, f, e)));
            chk("R9 wr_avail model", wr_avail, int'(used_m[2] < exp_cap(2, f, e)));
            eacc = v && (used_m[ep] < exp_cap(ep, f, e));
            chk("R10 accept model", a, int'(eacc));
            if (v) chk(fn ? "R2 class model" : "R3 class model", c, ec);
            g = '0;
            if (eacc) g[ep] = 1'b1;
            for (int i = 0; i < 3; i++) begin
               if (g[i] && !(rl[i] && used_m[i] != 0)) used_m[i]++;
               else if (!g[i] && rl[i] && used_m[i] != 0) used_m[i]--;
            end
         end
      end
      idle();

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule